// File: doc/BRIEF.md
# Counter-Balanced Frame Replacement Selector

This block keeps one occupancy counter for each of a small set of physical page frames and names a frame to give up when memory management needs room. Every time a new page is bound to a frame, that frame's counter goes up by one. When a bound page is no longer needed, the counter goes down by one. A victim request returns the frame that carries the fewest pages. This spreads heavily used pages across all frames so they do not crowd into a few.

Ties on the smallest count go to the frame whose latest associate is oldest. A frame that has not been associated since reset counts as older than any frame that has. Among such frames, the lowest index wins. Age comes from a global sequence counter that advances on each associate and is stamped into the associated frame. Ages are compared as distances from the current sequence value.

The victim answer is computed combinationally from the counters and stamps. It is flagged valid in the cycle after the request is registered. A release aimed at an empty frame is reported on a one-cycle error flag and leaves the counter at zero.

Top module: `frame_balance_sel`

## Requirements
- R1: After reset every counter is zero, `rel_err` and `vic_vld` are low, and a victim request with no associates since reset returns frame 0.
- R2: An associate to frame f (with no release to f in the same cycle) raises f's counter by exactly one.
- R3: A release to frame f with a nonzero counter (and no associate to f in the same cycle) lowers f's counter by exactly one.
- R4: The returned victim index is a frame whose counter is not larger than any other frame's counter.
- R5: Among frames tied on the smallest counter, the victim is the frame whose latest associate happened earliest. Frames never associated since reset rank before associated ones, and the lowest index wins among them.
- R6: A release to a frame whose counter is zero, with no associate to that frame in the same cycle, leaves the counter at zero and drives `rel_err` high for exactly the next cycle. `rel_err` is low after every other cycle.
- R7: A counter at its maximum value 2^CNT_W-1 (7 by default) stays there on a further associate and does not wrap.
- R8: An associate and a release to the same frame in the same cycle leave that counter unchanged and raise no error. The associate still refreshes that frame's age.
- R9: `vic_vld` is high in exactly the cycle after a cycle with `vic_req` high, and `vic_idx` is valid in that cycle.
- R10: An associate and a release to different frames in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| assoc_vld | input | 1 | Associate a new page with frame `assoc_idx` |
| assoc_idx | input | IDX_W | Frame receiving the page |
| rel_vld | input | 1 | Release a page from frame `rel_idx` |
| rel_idx | input | IDX_W | Frame losing the page |
| vic_req | input | 1 | Ask for a victim frame |
| vic_vld | output | 1 | Victim answer valid, one cycle after `vic_req` |
| vic_idx | output | IDX_W | Selected victim frame |
| rel_err | output | 1 | Previous cycle released from an empty frame |

## Verification
The hardest condition to reach is a tie on the smallest counter between frames with different histories: some never associated, some associated long ago and later drained by releases. Only that case exercises the age ordering instead of the counter ordering. The stimulus builds these ties on purpose. It loads frames in a scrambled order, drains one back to the level of the others, and pushes one frame past saturation before draining it. A reference model in the bench predicts each victim. A seeded pseudo-random phase then mixes associates, releases and same-cycle collisions.

// File: rtl/fbs_pkg.sv
package fbs_pkg;
  typedef enum logic [1:0] {
    SLOT_HOLD = 2'b00,
    SLOT_INC  = 2'b01,
    SLOT_DEC  = 2'b10,
    SLOT_BOTH = 2'b11
  } slot_op_e;

  function automatic slot_op_e slot_op(input logic inc, input logic dec);
    return slot_op_e'({dec, inc});
  endfunction
endpackage

// File: rtl/fbs_slot.sv
module fbs_slot
  import fbs_pkg::*;
#(
  parameter int CW = 3,
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  input  logic [SW-1:0] seq,
  output logic [CW-1:0] cnt,
  output logic          loaded,
  output logic [SW-1:0] stamp,
  output logic          underflow
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  function automatic logic [CW-1:0] sat_step(input logic [CW-1:0] c, input slot_op_e op);
    unique case (op)
      SLOT_INC: return (c == CMAX) ? c : c + 1'b1;
      SLOT_DEC: return (c == '0) ? c : c - 1'b1;
      default:  return c;
    endcase
  endfunction

  slot_op_e op;
  assign op        = slot_op(inc, dec);
  assign underflow = (op == SLOT_DEC) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt    <= '0;
      loaded <= 1'b0;
      stamp  <= '0;
    end else begin
      cnt <= sat_step(cnt, op);
      if (inc) begin
        loaded <= 1'b1;
        stamp  <= seq;
      end
    end
  end
endmodule

// File: rtl/fbs_argmin.sv
module fbs_argmin #(
  parameter int NF    = 4,
  parameter int CW    = 3,
  parameter int SW    = 8,
  parameter int IDX_W = 2
) (
  input  logic [NF*CW-1:0] cnt_flat,
  input  logic [NF-1:0]    loaded,
  input  logic [NF*SW-1:0] stamp_flat,
  input  logic [SW-1:0]    seq,
  output logic [IDX_W-1:0] best_idx
);
  localparam int KW = CW + SW + 1;

  // Lower key wins: counter first, then age rank (never-loaded ranks lowest).
  function automatic logic [KW-1:0] rank_key(input logic [CW-1:0] c, input logic ld,
                                             input logic [SW-1:0] st, input logic [SW-1:0] now);
    logic [SW-1:0] elapsed;
    elapsed = now - st;
    return ld ? {c, 1'b1, ~elapsed} : {c, 1'b0, {SW{1'b0}}};
  endfunction

  logic [KW-1:0] key [NF];

  for (genvar g = 0; g < NF; g++) begin : g_key
    assign key[g] = rank_key(cnt_flat[g*CW +: CW], loaded[g], stamp_flat[g*SW +: SW], seq);
  end

  always_comb begin
    logic [KW-1:0] best_key;
    best_idx = '0;
    best_key = key[0];
    for (int i = 1; i < NF; i++) begin
      if (key[i] < best_key) begin
        best_idx = IDX_W'(i);
        best_key = key[i];
      end
    end
  end
endmodule

// File: rtl/frame_balance_sel.sv
module frame_balance_sel #(
  parameter int NF    = 4,
  parameter int CW    = 3,
  parameter int SW    = 8,
  parameter int IDX_W = $clog2(NF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             assoc_vld,
  input  logic [IDX_W-1:0] assoc_idx,
  input  logic             rel_vld,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic             vic_req,
  output logic             vic_vld,
  output logic [IDX_W-1:0] vic_idx,
  output logic             rel_err
);
  logic [SW-1:0]    seq_q;
  logic [NF-1:0]    inc_evt, dec_evt, under;
  logic [NF-1:0]    loaded;
  logic [NF*CW-1:0] cnt_flat;
  logic [NF*SW-1:0] stamp_flat;

  for (genvar g = 0; g < NF; g++) begin : g_slot
    assign inc_evt[g] = assoc_vld && (assoc_idx == IDX_W'(g));
    assign dec_evt[g] = rel_vld   && (rel_idx   == IDX_W'(g));

    fbs_slot #(.CW(CW), .SW(SW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (inc_evt[g]),
      .dec      (dec_evt[g]),
      .seq      (seq_q),
      .cnt      (cnt_flat[g*CW +: CW]),
      .loaded   (loaded[g]),
      .stamp    (stamp_flat[g*SW +: SW]),
      .underflow(under[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq_q   <= '0;
      rel_err <= 1'b0;
      vic_vld <= 1'b0;
    end else begin
      if (assoc_vld) seq_q <= seq_q + 1'b1;
      rel_err <= |under;
      vic_vld <= vic_req;
    end
  end

  fbs_argmin #(.NF(NF), .CW(CW), .SW(SW), .IDX_W(IDX_W)) u_argmin (
    .cnt_flat  (cnt_flat),
    .loaded    (loaded),
    .stamp_flat(stamp_flat),
    .seq       (seq_q),
    .best_idx  (vic_idx)
  );
endmodule

// File: rtl/fbs_chk.sv
module fbs_chk #(
  parameter int NF    = 4,
  parameter int CW    = 3,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             vic_req,
  input logic             vic_vld,
  input logic [IDX_W-1:0] vic_idx,
  input logic             rel_vld,
  input logic             rel_err,
  input logic [NF-1:0]    inc_evt,
  input logic [NF-1:0]    dec_evt,
  input logic [NF*CW-1:0] cnt_flat
);
  localparam logic [CW-1:0] CMAX = {CW{1'b1}};

  // R9
  vic_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vic_req |=> vic_vld);
  // R9
  vic_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vic_req |=> !vic_vld);
  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rel_err |-> $past(rel_vld));

  for (genvar g = 0; g < NF; g++) begin : g_chk
    // R2
    inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_evt[g] && !dec_evt[g] && cnt_flat[g*CW +: CW] != CMAX) |=>
      cnt_flat[g*CW +: CW] == $past(cnt_flat[g*CW +: CW]) + 1'b1);
    // R3
    dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_evt[g] && !inc_evt[g] && cnt_flat[g*CW +: CW] != '0) |=>
      cnt_flat[g*CW +: CW] == $past(cnt_flat[g*CW +: CW]) - 1'b1);
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_evt[g] && !dec_evt[g] && cnt_flat[g*CW +: CW] == CMAX) |=>
      cnt_flat[g*CW +: CW] == CMAX);
    // R8
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_evt[g] && dec_evt[g]) |=> $stable(cnt_flat[g*CW +: CW]));
    // R4
    vic_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
      vic_vld |-> cnt_flat[vic_idx*CW +: CW] <= cnt_flat[g*CW +: CW]);
  end
endmodule

bind frame_balance_sel fbs_chk #(.NF(NF), .CW(CW), .IDX_W(IDX_W)) u_fbs_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .vic_req (vic_req),
  .vic_vld (vic_vld),
  .vic_idx (vic_idx),
  .rel_vld (rel_vld),
  .rel_err (rel_err),
  .inc_evt (inc_evt),
  .dec_evt (dec_evt),
  .cnt_flat(cnt_flat)
);

// File: tb/test_frame_balance_sel.sv
`timescale 1ns/1ps
module test_frame_balance_sel;
  localparam int NF = 4;
  localparam int CW = 3;
  localparam int IW = 2;
  localparam int CMAX = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic assoc_vld = 1'b0, rel_vld = 1'b0, vic_req = 1'b0;
  logic [IW-1:0] assoc_idx = '0, rel_idx = '0;
  logic vic_vld, rel_err;
  logic [IW-1:0] vic_idx;

  always #2 clk = ~clk;

  frame_balance_sel #(.NF(NF), .CW(CW), .SW(8)) i_frame_balance_sel (
    .clk(clk), .rst_n(rst_n),
    .assoc_vld(assoc_vld), .assoc_idx(assoc_idx),
    .rel_vld(rel_vld), .rel_idx(rel_idx),
    .vic_req(vic_req), .vic_vld(vic_vld), .vic_idx(vic_idx), .rel_err(rel_err)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model
  int m_cnt [NF];
  bit m_ld  [NF];
  int m_age [NF];
  int m_seq = 0;

  int exp_q [$];
  string tag_q [$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_victim();
    int b = 0;
    for (int i = 1; i < NF; i++) begin
      if (m_cnt[i] < m_cnt[b]) b = i;
      else if (m_cnt[i] == m_cnt[b]) begin
        if (!m_ld[i] && m_ld[b]) b = i;
        else if (m_ld[i] && m_ld[b] && m_age[i] < m_age[b]) b = i;
      end
    end
    return b;
  endfunction

  // one cycle of associate/release, then check rel_err (R6)
  task automatic op(input bit av, input int ai, input bit rv, input int ri, input string tag);
    bit e = 0;
    @(negedge clk);
    assoc_vld = av; assoc_idx = IW'(ai);
    rel_vld = rv;   rel_idx = IW'(ri);
    if (av) begin m_ld[ai] = 1; m_age[ai] = m_seq; m_seq++; end
    if (av && rv && ai == ri) begin
      // R8: no change
    end else begin
      if (av && m_cnt[ai] < CMAX) m_cnt[ai]++;
      if (rv) begin
        if (m_cnt[ri] == 0) e = 1;
        else m_cnt[ri]--;
      end
    end
    @(negedge clk);
    assoc_vld = 0; rel_vld = 0;
    chk(rel_err == e, {"R6 rel_err ", tag}, rel_err, e);
  endtask

  // driver: push expected victim, one-cycle request
  task automatic req(input string tag);
    @(negedge clk);
    exp_q.push_back(model_victim());
    tag_q.push_back(tag);
    vic_req = 1;
    @(negedge clk);
    vic_req = 0;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (vic_vld) begin
        if (exp_q.size() == 0) chk(0, "R9 vic_vld without request", 1, 0);
        else begin
          int e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(vic_idx == IW'(e), t, vic_idx, e);
        end
      end else if (exp_q.size() > 0 && !vic_req) begin
        chk(0, "R9 vic_vld missing", 0, 1);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
  end

  initial begin
    for (int i = 0; i < NF; i++) begin m_cnt[i] = 0; m_ld[i] = 0; m_age[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(rel_err == 0, "R1 rel_err after reset", rel_err, 0);
    chk(vic_vld == 0, "R1 vic_vld after reset", vic_vld, 0);
    req("R1 victim after reset");

    // scrambled load order 2,0,1,3
    op(1, 2, 0, 0, "R2 a2");  req("R5 unloaded frame 0 first");
    op(1, 0, 0, 0, "R2 a0");  req("R5 unloaded frame 1");
    op(1, 1, 0, 0, "R2 a1");  req("R5 unloaded frame 3");
    op(1, 3, 0, 0, "R2 a3");  req("R5 all one, oldest is 2");
    op(1, 2, 0, 0, "R2 a2b"); req("R2 frame 2 raised, oldest 0");
    op(0, 0, 1, 0, "R3 r0");  req("R3 frame 0 drained");
    op(0, 0, 1, 0, "R6 r0 underflow");
    req("R6 frame 0 held at zero");
    op(1, 0, 0, 0, "R2 a0b"); op(1, 0, 0, 0, "R2 a0c");
    req("R4 frame 1 lowest");
    op(0, 0, 1, 2, "R3 r2"); op(0, 0, 1, 2, "R3 r2b");
    req("R4 frame 2 drained to zero");
    // saturation
    for (int k = 0; k < 9; k++) op(1, 3, 0, 0, "R7 a3");
    for (int k = 0; k < 7; k++) op(0, 0, 1, 3, "R7 r3");
    req("R7 frame 3 back to zero");
    op(0, 0, 1, 3, "R7 underflow after drain");
    // same-frame collisions
    op(1, 2, 1, 2, "R8 both on empty frame");
    req("R8 frame order after refresh");
    op(1, 1, 1, 1, "R8 both on frame 1");
    req("R8 counters unchanged");
    // different frames in one cycle
    op(1, 2, 1, 0, "R10 a2 r0");
    req("R10 both applied");
    // back-to-back requests
    @(negedge clk);
    exp_q.push_back(model_victim()); tag_q.push_back("R9 b2b first");
    vic_req = 1;
    @(negedge clk);
    exp_q.push_back(model_victim()); tag_q.push_back("R9 b2b second");
    @(negedge clk);
    vic_req = 0;
    // pseudo-random mix
    begin
      logic [15:0] lf = 16'hACE1;
      for (int k = 0; k < 40; k++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        op(lf[0], int'(lf[2:1]), lf[3], int'(lf[5:4]), "R4 random op");
        if (k % 3 == 2) req("R4 random victim");
      end
    end
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule